// File: doc/BRIEF.md
# Logical Bitmask Immediate Expander

This block turns the compact three-field immediate of a logical instruction into the full 64-bit operand mask. The three fields are a wide-element flag, a 6-bit rotate amount and a 6-bit length selector. A mode input says whether the operand is 32 or 64 bits wide. The result comes out of one register stage, together with a flag that says whether the field triple is a legal encoding.

The element size is a power of two from 2 to 64. It is found from the highest set bit of a 7-bit code. That code has the wide flag on top and the bitwise inverse of the length selector below it. Inside the element there is a contiguous run of ones, starting at bit 0. The run is rotated right within the element, and the element is then repeated to fill the word.

The decode stage of a datapath uses this block. It presents the fields with a strobe and picks up the mask one clock later.

Top module: `bmask_expand`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. A synchronous active-high `rst` clears `out_valid`, `out_legal` and `out_mask`.
- R2: The size code is `{in_wide, ~in_len}`. The index of its highest set bit is the element size exponent (element = 2^exp bits). A code of zero is illegal, and so is an exponent of 0.
- R3: When `in_half` is 1, a 64-bit element (`in_wide` = 1) is illegal.
- R4: With levels = 2^exp − 1, the run length field is `in_len & levels`. If it equals levels, the encoding is illegal. A legal mask is never all zeros and never all ones.
- R5: The element holds (run length field + 1) ones at its low end. It is rotated right by `in_rot & levels` places inside the element, and bits leaving bit 0 re-enter at the element's top bit.
- R6: The rotated element is repeated across all 64 bits, so that bit i of the mask equals element bit (i mod 2^exp).
- R7: When `in_half` is 1, `out_mask[63:32]` is zero.
- R8: When `out_legal` is 0, `out_mask` is zero.
- R9: In a clock where `in_valid` is 0, `out_mask` and `out_legal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field triple strobe |
| in_wide | input | 1 | Wide-element flag (top bit of the size code) |
| in_rot | input | 6 | Rotate amount |
| in_len | input | 6 | Length and size selector |
| in_half | input | 1 | 1 = 32-bit operand, 0 = 64-bit operand |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_mask | output | 64 | Expanded mask |
| out_legal | output | 1 | Encoding is legal |

## Verification
Every result (mask, legality and strobe) is due exactly one clock edge after the inputs are presented. The bench drives inputs at the falling edge. At the next falling edge it compares the outputs against a loop-based reference that was computed when those inputs were driven. This keeps every comparison half a period away from the edge that loads the register.

In cycles with the strobe low, the reference keeps its last expected mask. This lets the same comparison cover holding of the outputs.

// File: rtl/bmask_pkg.sv
package bmask_pkg;

    localparam int WORD_W  = 64;
    localparam int FIELD_W = 6;
    localparam int CODE_W  = FIELD_W + 1;
    localparam int EXP_W   = $clog2(CODE_W);
    localparam int EXP_MAX = CODE_W - 1;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SLOTS   = 1 << EXP_W;

    typedef struct packed {
        logic               wide;
        logic [FIELD_W-1:0] rot;
        logic [FIELD_W-1:0] len;
        logic               half;
    } imm_fields_t;

    typedef struct packed {
        logic               legal;
        logic [EXP_W-1:0]   exp;
        logic [FIELD_W-1:0] run;
        logic [FIELD_W-1:0] shift;
    } elem_desc_t;

    function automatic logic [EXP_W-1:0] top_bit_index(input logic [CODE_W-1:0] code);
        logic [EXP_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (code[i]) idx = EXP_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [FIELD_W-1:0] level_mask(input logic [EXP_W-1:0] e);
        logic [FIELD_W-1:0] m;
        for (int i = 0; i < FIELD_W; i++) begin
            m[i] = (i < int'(e));
        end
        return m;
    endfunction

endpackage

// File: rtl/bmask_geom.sv
module bmask_geom
    import bmask_pkg::*;
(
    input  imm_fields_t fields,
    output elem_desc_t  desc
);
    logic [CODE_W-1:0]  code;
    logic [EXP_W-1:0]   exp_w;
    logic [FIELD_W-1:0] levels;
    logic [FIELD_W-1:0] run_w;

    always_comb begin
        code   = {fields.wide, ~fields.len};
        exp_w  = top_bit_index(code);
        levels = level_mask(exp_w);
        run_w  = fields.len & levels;

        desc.exp   = exp_w;
        desc.run   = run_w;
        desc.shift = fields.rot & levels;
        desc.legal = (code != '0)
                   && (exp_w != '0)
                   && !(fields.half && (exp_w == EXP_W'(EXP_MAX)))
                   && (run_w != levels);
    end
endmodule

// File: rtl/bmask_rotor.sv
module bmask_rotor
    import bmask_pkg::*;
#(
    parameter int EXP = 1
) (
    input  logic [FIELD_W-1:0] run,
    input  logic [FIELD_W-1:0] shift,
    output logic [(1<<EXP)-1:0] elem
);
    localparam int E = 1 << EXP;

    logic [E-1:0]   ones;
    logic [2*E-1:0] twice;

    always_comb begin
        for (int i = 0; i < E; i++) begin
            ones[i] = (i <= int'(run));
        end
        twice = {ones, ones} >> shift;
        elem  = twice[E-1:0];
    end
endmodule

// File: rtl/bmask_fill.sv
module bmask_fill
    import bmask_pkg::*;
(
    input  elem_desc_t        desc,
    input  logic              half,
    output logic [WORD_W-1:0] mask
);
    logic [WORD_W-1:0] rep [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_size
        if (k >= 1 && k <= EXP_MAX) begin : g_real
            localparam int E = 1 << k;
            logic [E-1:0] elem;
            bmask_rotor #(.EXP(k)) u_rotor (
                .run   (desc.run),
                .shift (desc.shift),
                .elem  (elem)
            );
            assign rep[k] = {(WORD_W/E){elem}};
        end else begin : g_none
            assign rep[k] = '0;
        end
    end

    logic [WORD_W-1:0] picked;

    always_comb begin
        picked = rep[desc.exp];
        if (!desc.legal) begin
            mask = '0;
        end else if (half) begin
            mask = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        end else begin
            mask = picked;
        end
    end
endmodule

// File: rtl/bmask_expand.sv
module bmask_expand
    import bmask_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_wide,
    input  logic [FIELD_W-1:0] in_rot,
    input  logic [FIELD_W-1:0] in_len,
    input  logic               in_half,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_mask,
    output logic               out_legal
);
    imm_fields_t       fields;
    elem_desc_t        desc;
    logic [WORD_W-1:0] mask_c;

    assign fields = '{wide: in_wide, rot: in_rot, len: in_len, half: in_half};

    bmask_geom u_geom (
        .fields (fields),
        .desc   (desc)
    );

    bmask_fill u_fill (
        .desc (desc),
        .half (in_half),
        .mask (mask_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_legal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask  <= mask_c;
                out_legal <= desc.legal;
            end
        end
    end
endmodule

// File: rtl/bmask_expand_chk.sv
module bmask_expand_chk
    import bmask_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_wide,
    input logic [FIELD_W-1:0] in_rot,
    input logic [FIELD_W-1:0] in_len,
    input logic               in_half,
    input logic               out_valid,
    input logic [WORD_W-1:0]  out_mask,
    input logic               out_legal
);
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_half_no_wide: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half && in_wide) |=> !out_legal);

    a_r4_not_uniform: assert property (@(posedge clk) disable iff (rst)
        out_legal |-> (out_mask != '0) && (out_mask != '1));

    a_r7_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half) |=> (out_mask[WORD_W-1:HALF_W] == '0));

    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        !out_legal |-> (out_mask == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_mask) && $stable(out_legal));
endmodule

bind bmask_expand bmask_expand_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .in_rot    (in_rot),
    .in_len    (in_len),
    .in_half   (in_half),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_legal (out_legal)
);

// File: tb/bmask_expand_bench.sv
`timescale 1ns/1ps
module bmask_expand_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic [5:0]  in_rot = '0;
    logic [5:0]  in_len = '0;
    logic        in_half = 1'b0;
    logic        out_valid;
    logic [63:0] out_mask;
    logic        out_legal;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic        exp_valid = 1'b0;
    logic [63:0] exp_mask = '0;
    logic        exp_legal = 1'b0;
    string       exp_tag = "R1";
    bit          pending = 0;

    always #10 clk = ~clk;

    bmask_expand u_bmask_expand (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
        .in_rot(in_rot), .in_len(in_len), .in_half(in_half),
        .out_valid(out_valid), .out_mask(out_mask), .out_legal(out_legal)
    );

    function automatic void model(input logic w, input logic [5:0] r, input logic [5:0] s,
                                  input logic h, output logic legal, output logic [63:0] m,
                                  output string tag);
        logic [6:0]  code;
        int          e, size, lv, run, sh;
        logic [63:0] base, rot;
        code = {w, ~s};
        e = -1;
        for (int i = 6; i >= 0; i--) if (e < 0 && code[i]) e = i;
        m = '0;
        legal = 1'b0;
        if (e <= 0) begin tag = "R2"; return; end
        if (h && e == 6) begin tag = "R3"; return; end
        size = 1 << e;
        lv = size - 1;
        run = int'(s) & lv;
        sh  = int'(r) & lv;
        if (run == lv) begin tag = "R4"; return; end
        base = '0;
        for (int i = 0; i <= run; i++) base[i] = 1'b1;
        rot = '0;
        for (int i = 0; i < size; i++) rot[i] = base[(i + sh) % size];
        for (int i = 0; i < 64; i++) m[i] = rot[i % size];
        if (h) begin
            for (int i = 32; i < 64; i++) m[i] = 1'b0;
            tag = "R7";
        end else if (e < 6) tag = "R6";
        else tag = "R5";
        legal = 1'b1;
    endfunction

    task automatic compare_pending();
        if (!pending) return;
        checks++;
        if (out_valid !== exp_valid || out_legal !== exp_legal || out_mask !== exp_mask) begin
            failures++;
            $display("FAIL %s: got v=%b l=%b m=%h expected v=%b l=%b m=%h",
                     exp_tag, out_valid, out_legal, out_mask, exp_valid, exp_legal, exp_mask);
        end
        if (!out_legal) begin
            checks++;
            if (out_mask !== 64'h0) begin
                failures++;
                $display("FAIL R8: got m=%h expected m=%h", out_mask, 64'h0);
            end
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [5:0] r,
                        input logic [5:0] s, input logic h);
        logic        l;
        logic [63:0] m;
        string       t;
        @(negedge clk);
        compare_pending();
        in_valid = v; in_wide = w; in_rot = r; in_len = s; in_half = h;
        exp_valid = v;
        if (v) begin
            model(w, r, s, h, l, m, t);
            exp_legal = l;
            exp_mask = m;
            exp_tag = t;
        end else begin
            exp_tag = "R9 R1";
        end
        pending = 1;
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5eed_0217);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_legal !== 1'b0 || out_mask !== 64'h0) begin
            failures++;
            $display("FAIL R1: reset got v=%b l=%b m=%h expected v=0 l=0 m=0",
                     out_valid, out_legal, out_mask);
        end
        rst = 1'b0;

        // Directed corners
        step(1, 0, 6'd0, 6'd0, 0);
        step(0, 1, 6'd5, 6'd3, 1);
        step(0, 0, 6'd9, 6'd60, 0);
        step(1, 1, 6'd1, 6'd62, 0);
        step(1, 1, 6'd63, 6'd63, 0);
        step(1, 0, 6'd63, 6'd63, 1);
        step(1, 0, 6'd1, 6'h3c, 0);
        step(1, 1, 6'd0, 6'd0, 1);
        step(1, 0, 6'd31, 6'd30, 1);

        // Exhaustive sweep, both modes
        for (int h = 0; h < 2; h++)
            for (int w = 0; w < 2; w++)
                for (int r = 0; r < 64; r++)
                    for (int s = 0; s < 64; s++)
                        step(1, w[0], r[5:0], s[5:0], h[0]);

        // Random traffic with gaps in the strobe
        for (int k = 0; k < 3000; k++) begin
            int unsigned x;
            x = $urandom;
            step(x[0] | x[1], x[2], x[8:3], x[14:9], x[15]);
        end

        @(negedge clk);
        compare_pending();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R1: watchdog expired, got no completion expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule